// File: doc/BRIEF.md
# Ethernet PHY Strap Configuration Resolver

This block works out the operating configuration of an Ethernet physical-layer device. It takes two inputs for each feature: a level on a board strap pin and a control bit from the management register file. It then produces the resolved controls that the rest of the PHY uses. These are the management address, the advertised abilities, whether autonegotiation runs, speed, duplex, fiber mode, power-down, isolate, loopback and 5B symbol pass-through.

Each feature has its own rule for when the pin decides and when the register bit decides. The block also works out the output enables for the media-independent interface pins. What it releases while isolated depends on whether the device is straps as a repeater.

Every strap pin passes through a synchronizer before it is used. The management address and the advertised abilities are captured on rising edges of the synchronized pins. The speed and duplex result from autonegotiation is captured from a done strobe driven by an external negotiation engine. A companion open-drain style output pulls the duplex strap low when a negotiated link ends up half duplex.

Top module: `phy_strap_cfg`

## Requirements
- R1: On a rising edge of the synchronized management-reset strap, `phy_addr` captures {collision strap, link strap, select straps}: bit 4 = collision, bit 3 = link, bits 2..0 = select. At all other times it holds its value.
- R2: While the synchronized autonegotiation strap is low, `speed100` equals the speed strap and `full_duplex` equals the duplex strap.
- R3: `adv_speed100`/`adv_full` load the speed and duplex straps on a rising edge of the autonegotiation strap, or on a management-reset rising edge while that strap is high. They hold their value otherwise.
- R4: `an_active` is high exactly when the autonegotiation strap, `reg_an_en` and not fiber mode all hold. With the strap high but negotiation off, speed follows the speed strap and duplex follows `reg_duplex`.
- R5: While `an_active` is high, `speed100`/`full_duplex` change only in the cycle after `an_done` is sampled high. In that cycle they take `an_res_speed100`/`an_res_full`. They read 0 until the first result arrives.
- R6: After a negotiated result, `duplex_drive_low` is 1 for a half-duplex result and 0 for a full-duplex result. It is 0 while negotiation is inactive.
- R7: With the fiber strap low, `fiber_mode` is 0. With it high, `fiber_mode` follows `reg_fiber`. `power_down` is high exactly when fiber mode is on and the speed strap is low.
- R8: The isolate strap high forces `isolate` on. With that strap low, `isolate` follows `reg_isolate`.
- R9: Isolated with the repeater strap low, all ten enables are 0 and `txen_gated` is 0 whatever `mii_txen` is. Enable order is {txclk, rxclk, rxd[3:0], rxdv, rxer, crs, col}.
- R10: Isolated with the repeater strap high, only the rxclk, rxd, rxdv and rxer enables are 0. The txclk, crs and col enables stay 1 and `txen_gated` follows `mii_txen`.
- R11: The loopback strap low forces `loopback` on. With that strap high, `loopback` follows `reg_loopback`.
- R12: The pass-through strap low forces `pass_through` on. With that strap high, `pass_through` follows `reg_pass`.
- R13: While `rst_n` is low, all MII output enables are 1 even if isolate is requested. `phy_addr` and the advertised abilities reset to 0.
- R14: A strap change does not reach any resolved output after one clock edge. It does reach the outputs after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mgmt_rst | input | 1 | Management reset strap; rising edge latches address |
| pin_sel | input | SEL_W | Address select straps |
| pin_link | input | 1 | Link strap, address bit SEL_W |
| pin_col | input | 1 | Collision strap, address bit SEL_W+1 |
| pin_an_en | input | 1 | Autonegotiation enable strap |
| pin_speed | input | 1 | Speed strap, 1 = 100 Mb/s |
| pin_duplex | input | 1 | Duplex strap, 1 = full |
| pin_fiber | input | 1 | Fiber strap |
| pin_isolate | input | 1 | Isolate strap, active high |
| pin_loopback_n | input | 1 | Loopback strap, active low |
| pin_pass_n | input | 1 | 5B pass-through strap, active low |
| pin_repeater | input | 1 | Repeater-mode strap |
| reg_an_en | input | 1 | Control register negotiation enable bit |
| reg_duplex | input | 1 | Control register duplex bit |
| reg_isolate | input | 1 | Control register isolate bit |
| reg_loopback | input | 1 | Control register loopback bit |
| reg_fiber | input | 1 | Extended register fiber bit |
| reg_pass | input | 1 | Extended register pass-through bit |
| an_done | input | 1 | Negotiation result strobe |
| an_res_speed100 | input | 1 | Negotiated speed |
| an_res_full | input | 1 | Negotiated duplex |
| mii_txen | input | 1 | Transmit enable from MAC |
| phy_addr | output | SEL_W+2 | Latched management address |
| adv_speed100 | output | 1 | Advertised 100 Mb/s ability |
| adv_full | output | 1 | Advertised full-duplex ability |
| an_active | output | 1 | Negotiation running |
| speed100 | output | 1 | Resolved speed |
| full_duplex | output | 1 | Resolved duplex |
| duplex_drive_low | output | 1 | Pull duplex strap low |
| fiber_mode | output | 1 | Fiber path selected |
| power_down | output | 1 | Power-down request |
| isolate | output | 1 | Resolved isolate |
| loopback | output | 1 | Resolved loopback |
| pass_through | output | 1 | Resolved 5B pass-through |
| txen_gated | output | 1 | Transmit enable as accepted |
| oe_txclk | output | 1 | Transmit clock enable |
| oe_rxclk | output | 1 | Receive clock enable |
| oe_rxd | output | DATA_W | Receive data enables |
| oe_rxdv | output | 1 | Receive valid enable |
| oe_rxer | output | 1 | Receive error enable |
| oe_crs | output | 1 | Carrier sense enable |
| oe_col | output | 1 | Collision enable |

## Verification
The bench builds the block with its default parameters: three select straps, giving a five-bit address; four receive data lanes; and a two-stage synchronizer. With this depth the one-edge blind window of R14 can be checked directly. The capture results land on a known edge, three edges after the strap moves. The five-bit address lets the bench check that the link and collision straps land at bits 3 and 4. The four lanes give the ten-bit enable vector that the isolate-mask checks compare in both repeater settings.

// File: rtl/phy_strap_pkg.sv
package phy_strap_pkg;

  // Level of a strap at which the register bit takes over, and value forced otherwise
  localparam logic ISO_REG_LVL  = 1'b0;
  localparam logic ISO_FORCED   = 1'b1;
  localparam logic LB_REG_LVL   = 1'b1;
  localparam logic LB_FORCED    = 1'b1;
  localparam logic PASS_REG_LVL = 1'b1;
  localparam logic PASS_FORCED  = 1'b1;
  localparam logic FIB_REG_LVL  = 1'b1;
  localparam logic FIB_FORCED   = 1'b0;

  // Select between register bit and forced value according to strap level
  function automatic logic pin_or_reg(input logic pin, input logic reg_lvl,
                                      input logic reg_bit, input logic forced);
    return (pin == reg_lvl) ? reg_bit : forced;
  endfunction

  // Duplex source when negotiation is not running
  function automatic logic manual_duplex(input logic an_pin, input logic pin_dup,
                                         input logic reg_dup);
    return an_pin ? reg_dup : pin_dup;
  endfunction

  // Power-down: fiber path with 10 Mb/s requested
  function automatic logic want_power_down(input logic fib, input logic spd100);
    return fib & ~spd100;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg[0] <= '0;
    end else begin
      stg[0] <= d;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int SEL_W  = 3,
  localparam int ADDR_W = SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_mrst,
  input  logic              s_an_en,
  input  logic [SEL_W-1:0]  s_sel,
  input  logic              s_link,
  input  logic              s_col,
  input  logic              s_speed,
  input  logic              s_duplex,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              adv_speed100,
  output logic              adv_full,
  output logic              mrst_rise,
  output logic              an_rise,
  output logic              adv_load
);
  logic mrst_prev, an_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrst_prev <= 1'b0;
      an_prev   <= 1'b0;
    end else begin
      mrst_prev <= s_mrst;
      an_prev   <= s_an_en;
    end
  end

  assign mrst_rise = s_mrst & ~mrst_prev;
  assign an_rise   = s_an_en & ~an_prev;
  assign adv_load  = an_rise | (mrst_rise & s_an_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_addr <= '0;
    end else if (mrst_rise) begin
      phy_addr <= {s_col, s_link, s_sel};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_speed100 <= 1'b0;
      adv_full     <= 1'b0;
    end else if (adv_load) begin
      adv_speed100 <= s_speed;
      adv_full     <= s_duplex;
    end
  end
endmodule

// File: rtl/mode_resolve.sv
module mode_resolve
  import phy_strap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_an_en,
  input  logic s_speed,
  input  logic s_duplex,
  input  logic s_fiber,
  input  logic s_iso,
  input  logic s_lb_n,
  input  logic s_pass_n,
  input  logic reg_an_en,
  input  logic reg_duplex,
  input  logic reg_isolate,
  input  logic reg_loopback,
  input  logic reg_fiber,
  input  logic reg_pass,
  input  logic an_done,
  input  logic an_res_speed100,
  input  logic an_res_full,
  output logic an_active,
  output logic an_load,
  output logic speed100,
  output logic full_duplex,
  output logic duplex_drive_low,
  output logic fiber_mode,
  output logic power_down,
  output logic isolate,
  output logic loopback,
  output logic pass_through
);
  logic an_spd_q, an_full_q, an_have;

  assign fiber_mode   = pin_or_reg(s_fiber,  FIB_REG_LVL,  reg_fiber,    FIB_FORCED);
  assign isolate      = pin_or_reg(s_iso,    ISO_REG_LVL,  reg_isolate,  ISO_FORCED);
  assign loopback     = pin_or_reg(s_lb_n,   LB_REG_LVL,   reg_loopback, LB_FORCED);
  assign pass_through = pin_or_reg(s_pass_n, PASS_REG_LVL, reg_pass,     PASS_FORCED);
  assign power_down   = want_power_down(fiber_mode, s_speed);

  assign an_active = s_an_en & reg_an_en & ~fiber_mode;
  assign an_load   = an_active & an_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      an_spd_q  <= 1'b0;
      an_full_q <= 1'b0;
      an_have   <= 1'b0;
    end else if (!an_active) begin
      an_spd_q  <= 1'b0;
      an_full_q <= 1'b0;
      an_have   <= 1'b0;
    end else if (an_load) begin
      an_spd_q  <= an_res_speed100;
      an_full_q <= an_res_full;
      an_have   <= 1'b1;
    end
  end

  always_comb begin
    if (an_active) begin
      speed100    = an_spd_q;
      full_duplex = an_full_q;
    end else begin
      speed100    = s_speed;
      full_duplex = manual_duplex(s_an_en, s_duplex, reg_duplex);
    end
  end

  assign duplex_drive_low = an_active & an_have & ~an_full_q;
endmodule

// File: rtl/iso_mask.sv
module iso_mask #(
  parameter int DATA_W = 4
) (
  input  logic              rst_n,
  input  logic              isolate,
  input  logic              repeater,
  input  logic              mii_txen,
  output logic              oe_txclk,
  output logic              oe_rxclk,
  output logic [DATA_W-1:0] oe_rxd,
  output logic              oe_rxdv,
  output logic              oe_rxer,
  output logic              oe_crs,
  output logic              oe_col,
  output logic              txen_gated
);
  logic rx_off, side_off;

  // Receive-side outputs always float when isolated; the rest only outside repeater mode
  assign rx_off   = rst_n & isolate;
  assign side_off = rst_n & isolate & ~repeater;

  assign oe_rxclk = ~rx_off;
  assign oe_rxdv  = ~rx_off;
  assign oe_rxer  = ~rx_off;
  for (genvar g = 0; g < DATA_W; g++) begin : g_rxd
    assign oe_rxd[g] = ~rx_off;
  end

  assign oe_txclk   = ~side_off;
  assign oe_crs     = ~side_off;
  assign oe_col     = ~side_off;
  assign txen_gated = mii_txen & ~side_off;
endmodule

// File: rtl/phy_strap_cfg.sv
module phy_strap_cfg #(
  parameter int SEL_W       = 3,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_mgmt_rst,
  input  logic [SEL_W-1:0]  pin_sel,
  input  logic              pin_link,
  input  logic              pin_col,
  input  logic              pin_an_en,
  input  logic              pin_speed,
  input  logic              pin_duplex,
  input  logic              pin_fiber,
  input  logic              pin_isolate,
  input  logic              pin_loopback_n,
  input  logic              pin_pass_n,
  input  logic              pin_repeater,
  input  logic              reg_an_en,
  input  logic              reg_duplex,
  input  logic              reg_isolate,
  input  logic              reg_loopback,
  input  logic              reg_fiber,
  input  logic              reg_pass,
  input  logic              an_done,
  input  logic              an_res_speed100,
  input  logic              an_res_full,
  input  logic              mii_txen,
  output logic [SEL_W+1:0]  phy_addr,
  output logic              adv_speed100,
  output logic              adv_full,
  output logic              an_active,
  output logic              speed100,
  output logic              full_duplex,
  output logic              duplex_drive_low,
  output logic              fiber_mode,
  output logic              power_down,
  output logic              isolate,
  output logic              loopback,
  output logic              pass_through,
  output logic              txen_gated,
  output logic              oe_txclk,
  output logic              oe_rxclk,
  output logic [DATA_W-1:0] oe_rxd,
  output logic              oe_rxdv,
  output logic              oe_rxer,
  output logic              oe_crs,
  output logic              oe_col
);
  localparam int NPIN    = SEL_W + 11;
  localparam int IX_LINK = SEL_W;
  localparam int IX_COL  = SEL_W + 1;
  localparam int IX_AN   = SEL_W + 2;
  localparam int IX_SPD  = SEL_W + 3;
  localparam int IX_DUP  = SEL_W + 4;
  localparam int IX_FIB  = SEL_W + 5;
  localparam int IX_ISO  = SEL_W + 6;
  localparam int IX_LB   = SEL_W + 7;
  localparam int IX_PASS = SEL_W + 8;
  localparam int IX_REP  = SEL_W + 9;
  localparam int IX_MRST = SEL_W + 10;

  logic [NPIN-1:0] pin_vec, s_vec;
  logic s_rep, mrst_rise, an_rise, adv_load, an_load;

  assign pin_vec = {pin_mgmt_rst, pin_repeater, pin_pass_n, pin_loopback_n,
                    pin_isolate, pin_fiber, pin_duplex, pin_speed, pin_an_en,
                    pin_col, pin_link, pin_sel};

  strap_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_vec), .q(s_vec)
  );

  assign s_rep = s_vec[IX_REP];

  strap_capture #(.SEL_W(SEL_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .s_mrst(s_vec[IX_MRST]), .s_an_en(s_vec[IX_AN]),
    .s_sel(s_vec[SEL_W-1:0]), .s_link(s_vec[IX_LINK]), .s_col(s_vec[IX_COL]),
    .s_speed(s_vec[IX_SPD]), .s_duplex(s_vec[IX_DUP]),
    .phy_addr(phy_addr), .adv_speed100(adv_speed100), .adv_full(adv_full),
    .mrst_rise(mrst_rise), .an_rise(an_rise), .adv_load(adv_load)
  );

  mode_resolve u_mode (
    .clk(clk), .rst_n(rst_n),
    .s_an_en(s_vec[IX_AN]), .s_speed(s_vec[IX_SPD]), .s_duplex(s_vec[IX_DUP]),
    .s_fiber(s_vec[IX_FIB]), .s_iso(s_vec[IX_ISO]), .s_lb_n(s_vec[IX_LB]),
    .s_pass_n(s_vec[IX_PASS]),
    .reg_an_en(reg_an_en), .reg_duplex(reg_duplex), .reg_isolate(reg_isolate),
    .reg_loopback(reg_loopback), .reg_fiber(reg_fiber), .reg_pass(reg_pass),
    .an_done(an_done), .an_res_speed100(an_res_speed100), .an_res_full(an_res_full),
    .an_active(an_active), .an_load(an_load), .speed100(speed100),
    .full_duplex(full_duplex), .duplex_drive_low(duplex_drive_low),
    .fiber_mode(fiber_mode), .power_down(power_down), .isolate(isolate),
    .loopback(loopback), .pass_through(pass_through)
  );

  iso_mask #(.DATA_W(DATA_W)) u_iso (
    .rst_n(rst_n), .isolate(isolate), .repeater(s_rep), .mii_txen(mii_txen),
    .oe_txclk(oe_txclk), .oe_rxclk(oe_rxclk), .oe_rxd(oe_rxd),
    .oe_rxdv(oe_rxdv), .oe_rxer(oe_rxer), .oe_crs(oe_crs), .oe_col(oe_col),
    .txen_gated(txen_gated)
  );
endmodule

// File: rtl/phy_strap_chk.sv
module phy_strap_chk #(
  parameter int SEL_W  = 3,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mrst_rise,
  input logic              adv_load,
  input logic              an_load,
  input logic              s_rep,
  input logic              mii_txen,
  input logic [SEL_W+1:0]  phy_addr,
  input logic              adv_speed100,
  input logic              adv_full,
  input logic              an_active,
  input logic              speed100,
  input logic              full_duplex,
  input logic              duplex_drive_low,
  input logic              fiber_mode,
  input logic              power_down,
  input logic              isolate,
  input logic              txen_gated,
  input logic              oe_txclk,
  input logic              oe_rxclk,
  input logic [DATA_W-1:0] oe_rxd,
  input logic              oe_rxdv,
  input logic              oe_rxer,
  input logic              oe_crs,
  input logic              oe_col
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !mrst_rise) |=> $stable(phy_addr));

  // R3
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !adv_load) |=> ($stable(adv_speed100) && $stable(adv_full)));

  // R5
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && an_active && $past(an_active) && !$past(an_load))
      |-> ($stable(speed100) && $stable(full_duplex)));

  // R6
  dup_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duplex_drive_low |-> (!full_duplex && an_active));

  // R7
  fib_an_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiber_mode |-> !an_active);

  // R7
  pwr_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> fiber_mode);

  // R9
  iso_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isolate && !s_rep) |-> (!oe_txclk && !oe_crs && !oe_col && !oe_rxclk
                             && (oe_rxd == '0) && !txen_gated));

  // R10
  iso_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isolate && s_rep) |-> (oe_txclk && oe_crs && oe_col && !oe_rxdv && !oe_rxer
                            && (txen_gated == mii_txen)));
endmodule

bind phy_strap_cfg phy_strap_chk #(.SEL_W(SEL_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mrst_rise(mrst_rise), .adv_load(adv_load),
  .an_load(an_load), .s_rep(s_rep), .mii_txen(mii_txen), .phy_addr(phy_addr),
  .adv_speed100(adv_speed100), .adv_full(adv_full), .an_active(an_active),
  .speed100(speed100), .full_duplex(full_duplex),
  .duplex_drive_low(duplex_drive_low), .fiber_mode(fiber_mode),
  .power_down(power_down), .isolate(isolate), .txen_gated(txen_gated),
  .oe_txclk(oe_txclk), .oe_rxclk(oe_rxclk), .oe_rxd(oe_rxd), .oe_rxdv(oe_rxdv),
  .oe_rxer(oe_rxer), .oe_crs(oe_crs), .oe_col(oe_col)
);

// File: tb/test_phy_strap_cfg.sv
`timescale 1ns/1ps
module test_phy_strap_cfg;
  localparam int SEL_W = 3;
  localparam int DATA_W = 4;

  localparam int F_ADDR = 0, F_ADV = 1, F_AN = 2, F_SPD = 3, F_FULL = 4,
                 F_DLOW = 5, F_FIB = 6, F_PD = 7, F_ISO = 8, F_LB = 9,
                 F_PASS = 10, F_TXEN = 11, F_OE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_mgmt_rst = 0, pin_link = 0, pin_col = 1, pin_an_en = 0;
  logic [SEL_W-1:0] pin_sel = 3'b101;
  logic pin_speed = 1, pin_duplex = 1, pin_fiber = 0, pin_isolate = 0;
  logic pin_loopback_n = 1, pin_pass_n = 1, pin_repeater = 0;
  logic reg_an_en = 0, reg_duplex = 0, reg_isolate = 0, reg_loopback = 0;
  logic reg_fiber = 0, reg_pass = 0;
  logic an_done = 0, an_res_speed100 = 0, an_res_full = 0, mii_txen = 0;
  logic [SEL_W+1:0] phy_addr;
  logic adv_speed100, adv_full, an_active, speed100, full_duplex, duplex_drive_low;
  logic fiber_mode, power_down, isolate, loopback, pass_through, txen_gated;
  logic oe_txclk, oe_rxclk, oe_rxdv, oe_rxer, oe_crs, oe_col;
  logic [DATA_W-1:0] oe_rxd;

  always #2 clk = ~clk;

  phy_strap_cfg #(.SEL_W(SEL_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) i_phy_strap_cfg (
    .clk(clk), .rst_n(rst_n), .pin_mgmt_rst(pin_mgmt_rst), .pin_sel(pin_sel),
    .pin_link(pin_link), .pin_col(pin_col), .pin_an_en(pin_an_en),
    .pin_speed(pin_speed), .pin_duplex(pin_duplex), .pin_fiber(pin_fiber),
    .pin_isolate(pin_isolate), .pin_loopback_n(pin_loopback_n),
    .pin_pass_n(pin_pass_n), .pin_repeater(pin_repeater),
    .reg_an_en(reg_an_en), .reg_duplex(reg_duplex), .reg_isolate(reg_isolate),
    .reg_loopback(reg_loopback), .reg_fiber(reg_fiber), .reg_pass(reg_pass),
    .an_done(an_done), .an_res_speed100(an_res_speed100), .an_res_full(an_res_full),
    .mii_txen(mii_txen), .phy_addr(phy_addr), .adv_speed100(adv_speed100),
    .adv_full(adv_full), .an_active(an_active), .speed100(speed100),
    .full_duplex(full_duplex), .duplex_drive_low(duplex_drive_low),
    .fiber_mode(fiber_mode), .power_down(power_down), .isolate(isolate),
    .loopback(loopback), .pass_through(pass_through), .txen_gated(txen_gated),
    .oe_txclk(oe_txclk), .oe_rxclk(oe_rxclk), .oe_rxd(oe_rxd), .oe_rxdv(oe_rxdv),
    .oe_rxer(oe_rxer), .oe_crs(oe_crs), .oe_col(oe_col)
  );

  typedef struct {
    string       req;
    int          fld;
    logic [15:0] exp;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  function automatic logic [15:0] observe(int f);
    case (f)
      F_ADDR: return 16'(phy_addr);
      F_ADV:  return 16'({adv_speed100, adv_full});
      F_AN:   return 16'(an_active);
      F_SPD:  return 16'(speed100);
      F_FULL: return 16'(full_duplex);
      F_DLOW: return 16'(duplex_drive_low);
      F_FIB:  return 16'(fiber_mode);
      F_PD:   return 16'(power_down);
      F_ISO:  return 16'(isolate);
      F_LB:   return 16'(loopback);
      F_PASS: return 16'(pass_through);
      F_TXEN: return 16'(txen_gated);
      default: return 16'({oe_txclk, oe_rxclk, oe_rxd, oe_rxdv, oe_rxer, oe_crs, oe_col});
    endcase
  endfunction

  // Driver side: push an expected item
  task automatic expect_item(string req, int fld, logic [15:0] exp);
    item_t it;
    it.req = req; it.fld = fld; it.exp = exp;
    sb.push_back(it);
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = observe(it.fld);
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s field %0d: actual %h expected %h", it.req, it.fld, act, it.exp);
      end
    end
  end

  task automatic drive_pt();
    @(posedge clk);
    #1;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_done(logic spd, logic full);
    drive_pt();
    an_res_speed100 = spd; an_res_full = full; an_done = 1;
    drive_pt();
    an_done = 0;
    step(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R13: reset state, enables held on even with isolate requested
    reg_isolate = 1;
    step(3);
    expect_item("R13 oe in reset", F_OE, 16'h3FF);
    expect_item("R13 addr reset", F_ADDR, 16'd0);
    expect_item("R13 adv reset", F_ADV, 16'd0);
    drive_pt();
    reg_isolate = 0;
    drive_pt();
    rst_n = 1;
    step(4);
    expect_item("R1 no capture without edge", F_ADDR, 16'd0);
    expect_item("R2 speed from pin", F_SPD, 16'd1);
    expect_item("R2 duplex from pin", F_FULL, 16'd1);
    expect_item("R11 loopback off", F_LB, 16'd0);
    expect_item("R12 pass off", F_PASS, 16'd0);

    // R1: address capture, col=1 link=0 sel=101 -> 10101
    drive_pt(); pin_mgmt_rst = 1;
    step(4);
    expect_item("R1 address capture", F_ADDR, 16'd21);
    expect_item("R3 no advert load with an pin low", F_ADV, 16'd0);
    drive_pt(); pin_sel = 3'b010; pin_link = 1;
    step(4);
    expect_item("R1 address held", F_ADDR, 16'd21);

    // R2 other pattern
    drive_pt(); pin_speed = 0; pin_duplex = 0;
    step(4);
    expect_item("R2 speed low", F_SPD, 16'd0);
    expect_item("R2 duplex low", F_FULL, 16'd0);

    // R14 / R11: one edge is not enough
    drive_pt(); pin_loopback_n = 0;
    step(1);
    expect_item("R14 not yet after one edge", F_LB, 16'd0);
    step(2);
    expect_item("R11 loopback forced by pin", F_LB, 16'd1);
    drive_pt(); pin_loopback_n = 1; reg_loopback = 1;
    step(4);
    expect_item("R11 loopback from register", F_LB, 16'd1);
    drive_pt(); reg_loopback = 0;
    step(1);
    expect_item("R11 loopback register off", F_LB, 16'd0);

    // R12
    drive_pt(); pin_pass_n = 0;
    step(4);
    expect_item("R12 pass forced by pin", F_PASS, 16'd1);
    drive_pt(); pin_pass_n = 1; reg_pass = 1;
    step(4);
    expect_item("R12 pass from register", F_PASS, 16'd1);
    drive_pt(); reg_pass = 0;
    step(1);
    expect_item("R12 pass register off", F_PASS, 16'd0);

    // R3: advert on an pin rise
    drive_pt(); pin_speed = 1; pin_duplex = 0;
    step(4);
    drive_pt(); pin_an_en = 1;
    step(4);
    expect_item("R3 advert on an rise", F_ADV, 16'b10);
    expect_item("R4 an inactive with reg off", F_AN, 16'd0);
    expect_item("R4 speed from pin", F_SPD, 16'd1);
    expect_item("R4 duplex from register", F_FULL, 16'd0);
    drive_pt(); reg_duplex = 1;
    step(1);
    expect_item("R4 duplex register on", F_FULL, 16'd1);
    drive_pt(); pin_speed = 0; pin_duplex = 1;
    step(4);
    expect_item("R3 advert held", F_ADV, 16'b10);
    drive_pt(); pin_mgmt_rst = 0;
    step(4);
    drive_pt(); pin_mgmt_rst = 1;
    step(4);
    expect_item("R3 advert on mgmt reset rise", F_ADV, 16'b01);
    expect_item("R1 address bit3 link bit4 col", F_ADDR, 16'd26);
    drive_pt(); pin_speed = 1;
    step(4);

    // R4/R5/R6: negotiation
    drive_pt(); reg_an_en = 1;
    step(1);
    expect_item("R4 an active", F_AN, 16'd1);
    expect_item("R5 speed zero before result", F_SPD, 16'd0);
    expect_item("R6 no drive before result", F_DLOW, 16'd0);
    drive_pt(); an_res_speed100 = 1; an_res_full = 0;
    step(3);
    expect_item("R5 no update without done", F_SPD, 16'd0);
    pulse_done(1, 0);
    expect_item("R5 speed from result", F_SPD, 16'd1);
    expect_item("R5 duplex from result", F_FULL, 16'd0);
    expect_item("R6 drive low on half", F_DLOW, 16'd1);
    drive_pt(); an_res_full = 1;
    step(2);
    expect_item("R5 duplex held", F_FULL, 16'd0);
    pulse_done(1, 1);
    expect_item("R5 duplex updated", F_FULL, 16'd1);
    expect_item("R6 release on full", F_DLOW, 16'd0);

    // R7: fiber
    drive_pt(); pin_fiber = 1;
    step(4);
    expect_item("R7 fiber off with reg low", F_FIB, 16'd0);
    expect_item("R7 an still active", F_AN, 16'd1);
    drive_pt(); reg_fiber = 1;
    step(1);
    expect_item("R7 fiber on", F_FIB, 16'd1);
    expect_item("R7 fiber stops an", F_AN, 16'd0);
    expect_item("R6 released when an stops", F_DLOW, 16'd0);
    expect_item("R7 no power down at 100", F_PD, 16'd0);
    drive_pt(); pin_speed = 0;
    step(4);
    expect_item("R7 power down at 10", F_PD, 16'd1);
    drive_pt(); pin_fiber = 0;
    step(4);
    expect_item("R7 fiber pin low forces off", F_FIB, 16'd0);
    expect_item("R7 power down clears", F_PD, 16'd0);
    drive_pt(); reg_fiber = 0; pin_speed = 1;

    // R8/R9/R10: isolate
    drive_pt(); pin_isolate = 1; mii_txen = 1;
    step(4);
    expect_item("R8 isolate from pin", F_ISO, 16'd1);
    expect_item("R9 all enables off", F_OE, 16'h000);
    expect_item("R9 txen ignored", F_TXEN, 16'd0);
    drive_pt(); pin_repeater = 1;
    step(4);
    expect_item("R10 repeater mask", F_OE, 16'h203);
    expect_item("R10 txen accepted", F_TXEN, 16'd1);
    drive_pt(); mii_txen = 0;
    step(1);
    expect_item("R10 txen follows", F_TXEN, 16'd0);
    drive_pt(); pin_isolate = 0; reg_isolate = 1; pin_repeater = 0; mii_txen = 1;
    step(4);
    expect_item("R8 isolate from register", F_ISO, 16'd1);
    expect_item("R9 register isolate masks", F_OE, 16'h000);
    drive_pt(); reg_isolate = 0;
    step(1);
    expect_item("R8 isolate off", F_ISO, 16'd0);
    expect_item("R9 enables back", F_OE, 16'h3FF);
    expect_item("R9 txen passes", F_TXEN, 16'd1);

    step(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule